// File: doc/BRIEF.md
# Sequence-Numbered Store Queue with Early Drain

This block buffers in-flight stores in a circular array. Every store is named by a store sequence number (SSN) that climbs by one per dispatched store, and the low bits of that number pick the array slot. Three SSN registers mark the youngest dispatched store, the youngest committed store and the youngest store already written to the data cache. A store takes its number at dispatch and fills its slot with address and data when it executes.

A load never searches the array by address. It brings a predicted SSN from an outside predictor, reads only the slot that number selects, and learns one cycle later whether the slot could forward (hit, with data) or not (miss, so the load goes to the cache). Stores drain to the cache write port one per cycle, in SSN order, as soon as each one is committed. Commit moves one store at a time, so draining is not held back to a register checkpoint boundary. A squash pulls the dispatch register back to a given SSN, which discards the younger stores.

SSN 0 means "no store", so the first store after reset is numbered 1. The depth must be a power of two. SSNs are assumed not to wrap within the live window.

Top module: `ssn_store_queue`

## Requirements
- R1: After reset the dispatch, commit and complete registers all read 0, `disp_ready` is 1, and `wr_valid` and `ld_rsp_valid` are 0.
- R2: A dispatch request that is accepted gives the store the number `disp_ptr`+1, and `disp_ptr` takes that value at the next edge.
- R3: `disp_ready` is 0 exactly when `disp_ptr` minus `cmpl_ptr` equals DEPTH. A request made in such a cycle changes nothing.
- R4: An execute writes address and data into slot `exe_ssn` mod DEPTH. It is accepted only when `cmpl_ptr` < `exe_ssn` <= `disp_ptr` and that store has not yet executed. Any other execute is ignored.
- R5: A load request gets `ld_rsp_valid` one cycle later. `ld_hit` is 1 only if all of these hold: the predicted SSN lies in (`cmpl_ptr`, `disp_ptr`], that store has executed, and its address equals `ld_addr`. On a hit `ld_data` is the store's data; on a miss it is 0.
- R6: Each `commit_req` advances `cmt_ptr` by exactly one, but never past `disp_ptr`. In a cycle with an accepted squash, it never passes the squash SSN.
- R7: `wr_valid` is 1 when `cmpl_ptr` < `cmt_ptr` and store `cmpl_ptr`+1 has executed. The port then presents that store's address and data, which stay unchanged until `wr_ready`. Each handshake raises `cmpl_ptr` by one.
- R8: A squash with `cmt_ptr` <= `squash_ssn` <= `disp_ptr` sets `disp_ptr` to `squash_ssn` and overrides a dispatch in the same cycle. A squash outside that range is ignored.
- R9: A squashed SSN misses on loads and is ignored on execute until it is dispatched again. Re-dispatch leaves it unexecuted.
- R10: A load is judged against the registers as they stood before the edge. A load to the store that drains in the same cycle therefore still hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_req | input | 1 | Allocate the next SSN |
| disp_ready | output | 1 | Queue has a free slot |
| exe_valid | input | 1 | Store execute write |
| exe_ssn | input | SSN_W | SSN of the executing store |
| exe_addr | input | ADDR_W | Store address |
| exe_data | input | DATA_W | Store data |
| ld_valid | input | 1 | Load lookup request |
| ld_ssn | input | SSN_W | Predicted forwarding SSN |
| ld_addr | input | ADDR_W | Load address |
| ld_rsp_valid | output | 1 | Lookup result valid (one cycle after request) |
| ld_hit | output | 1 | Forwarding hit |
| ld_data | output | DATA_W | Forwarded data, 0 on miss |
| commit_req | input | 1 | Commit one more store |
| squash_req | input | 1 | Roll back dispatch register |
| squash_ssn | input | SSN_W | New dispatch SSN on squash |
| wr_valid | output | 1 | Cache write request |
| wr_ready | input | 1 | Cache accepts the write |
| wr_addr | output | ADDR_W | Cache write address |
| wr_data | output | DATA_W | Cache write data |
| disp_ptr | output | SSN_W | Youngest dispatched SSN |
| cmt_ptr | output | SSN_W | Youngest committed SSN |
| cmpl_ptr | output | SSN_W | Youngest completed SSN |

## Verification
The two functions that most often share a cycle are forwarding and draining: a load that names the store leaving through the cache port in that very cycle. The bench provokes this in a directed step that raises `wr_ready` alongside the load, and expects a hit on the pre-edge window. It then expects a miss one cycle later once the complete register has moved. A second collision, a squash together with a dispatch request and a commit request, is provoked both in a directed step and at random. A behavioural model built on integer counters and per-SSN arrays judges every cycle.

// File: rtl/sq_pkg.sv
package sq_pkg;
  // What a slot does at the next edge
  typedef enum logic [1:0] {
    SLOT_HOLD  = 2'd0,
    SLOT_CLEAR = 2'd1,
    SLOT_FILL  = 2'd2
  } slot_op_e;
endpackage

// File: rtl/sq_ptrs.sv
module sq_ptrs #(
  parameter int SSN_W = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_req,
  input  logic             commit_req,
  input  logic             squash_req,
  input  logic [SSN_W-1:0] squash_ssn,
  input  logic             drain_fire,
  output logic [SSN_W-1:0] disp_ptr,
  output logic [SSN_W-1:0] cmt_ptr,
  output logic [SSN_W-1:0] cmpl_ptr,
  output logic             disp_ready,
  output logic             disp_fire
);
  localparam logic [SSN_W-1:0] DEPTH_SSN = SSN_W'(DEPTH);
  localparam logic [SSN_W-1:0] ONE_SSN   = SSN_W'(1);

  logic             squash_ok;
  logic [SSN_W-1:0] cmt_lim;
  logic             disp_en, cmt_en, cmpl_en;
  logic [SSN_W-1:0] disp_nxt, cmt_nxt, cmpl_nxt;

  always_comb begin
    // legal squash target lies in [cmt_ptr, disp_ptr]
    squash_ok  = squash_req && ((squash_ssn - cmt_ptr) <= (disp_ptr - cmt_ptr));
    disp_ready = (disp_ptr - cmpl_ptr) != DEPTH_SSN;
    disp_fire  = disp_req && disp_ready && !squash_ok;
    cmt_lim    = squash_ok ? squash_ssn : disp_ptr;

    disp_en  = squash_ok || disp_fire;
    disp_nxt = squash_ok ? squash_ssn : (disp_ptr + ONE_SSN);
    cmt_en   = commit_req && (cmt_ptr != cmt_lim);
    cmt_nxt  = cmt_ptr + ONE_SSN;
    cmpl_en  = drain_fire;
    cmpl_nxt = cmpl_ptr + ONE_SSN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_ptr <= '0;
      cmt_ptr  <= '0;
      cmpl_ptr <= '0;
    end else begin
      if (disp_en) disp_ptr <= disp_nxt;
      if (cmt_en)  cmt_ptr  <= cmt_nxt;
      if (cmpl_en) cmpl_ptr <= cmpl_nxt;
    end
  end
endmodule

// File: rtl/sq_slots.sv
module sq_slots
  import sq_pkg::*;
#(
  parameter int SSN_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic              fill_en,
  input  logic [SSN_W-1:0]  fill_ssn,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  output logic [DEPTH-1:0]  slot_vld,
  output logic [SSN_W-1:0]  slot_tag  [DEPTH],
  output logic [ADDR_W-1:0] slot_addr [DEPTH],
  output logic [DATA_W-1:0] slot_data [DEPTH]
);
  logic [IDX_W-1:0] fill_idx;
  assign fill_idx = fill_ssn[IDX_W-1:0];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    slot_op_e op;
    logic     vld_nxt;

    always_comb begin
      op = SLOT_HOLD;
      if (fill_en && (fill_idx == IDX_W'(g)))     op = SLOT_FILL;
      else if (clr_en && (clr_idx == IDX_W'(g)))  op = SLOT_CLEAR;
      case (op)
        SLOT_FILL:  vld_nxt = 1'b1;
        SLOT_CLEAR: vld_nxt = 1'b0;
        default:    vld_nxt = slot_vld[g];
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_vld[g] <= 1'b0;
      else        slot_vld[g] <= vld_nxt;
    end

    // payload has no reset; it is qualified by slot_vld
    always_ff @(posedge clk) begin
      if (op == SLOT_FILL) begin
        slot_tag[g]  <= fill_ssn;
        slot_addr[g] <= fill_addr;
        slot_data[g] <= fill_data;
      end
    end
  end
endmodule

// File: rtl/sq_fwd.sv
module sq_fwd #(
  parameter int SSN_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [SSN_W-1:0]  ld_ssn,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [SSN_W-1:0]  disp_ptr,
  input  logic [SSN_W-1:0]  cmpl_ptr,
  input  logic [DEPTH-1:0]  slot_vld,
  input  logic [SSN_W-1:0]  slot_tag  [DEPTH],
  input  logic [ADDR_W-1:0] slot_addr [DEPTH],
  input  logic [DATA_W-1:0] slot_data [DEPTH],
  output logic              ld_rsp_valid,
  output logic              ld_hit,
  output logic [DATA_W-1:0] ld_data
);
  localparam logic [SSN_W-1:0] ONE_SSN = SSN_W'(1);

  logic [IDX_W-1:0]  idx;
  logic              in_win, hit_c;
  logic [DATA_W-1:0] data_c;

  always_comb begin
    idx    = ld_ssn[IDX_W-1:0];
    in_win = (ld_ssn - cmpl_ptr - ONE_SSN) < (disp_ptr - cmpl_ptr);
    hit_c  = ld_valid && in_win && slot_vld[idx] &&
             (slot_tag[idx] == ld_ssn) && (slot_addr[idx] == ld_addr);
    data_c = hit_c ? slot_data[idx] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_rsp_valid <= 1'b0;
      ld_hit       <= 1'b0;
    end else begin
      ld_rsp_valid <= ld_valid;
      ld_hit       <= hit_c;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_valid) ld_data <= data_c;
  end
endmodule

// File: rtl/ssn_store_queue.sv
module ssn_store_queue #(
  parameter int SSN_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_req,
  output logic              disp_ready,
  input  logic              exe_valid,
  input  logic [SSN_W-1:0]  exe_ssn,
  input  logic [ADDR_W-1:0] exe_addr,
  input  logic [DATA_W-1:0] exe_data,
  input  logic              ld_valid,
  input  logic [SSN_W-1:0]  ld_ssn,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_rsp_valid,
  output logic              ld_hit,
  output logic [DATA_W-1:0] ld_data,
  input  logic              commit_req,
  input  logic              squash_req,
  input  logic [SSN_W-1:0]  squash_ssn,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [SSN_W-1:0]  disp_ptr,
  output logic [SSN_W-1:0]  cmt_ptr,
  output logic [SSN_W-1:0]  cmpl_ptr
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [SSN_W-1:0] ONE_SSN = SSN_W'(1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  logic              disp_fire, drain_fire;
  logic [DEPTH-1:0]  slot_vld;
  logic [SSN_W-1:0]  slot_tag  [DEPTH];
  logic [ADDR_W-1:0] slot_addr [DEPTH];
  logic [DATA_W-1:0] slot_data [DEPTH];

  sq_ptrs #(.SSN_W(SSN_W), .DEPTH(DEPTH)) u_ptrs (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .disp_req   (disp_req),
    .commit_req (commit_req),
    .squash_req (squash_req),
    .squash_ssn (squash_ssn),
    .drain_fire (drain_fire),
    .disp_ptr   (disp_ptr),
    .cmt_ptr    (cmt_ptr),
    .cmpl_ptr   (cmpl_ptr),
    .disp_ready (disp_ready),
    .disp_fire  (disp_fire)
  );

  // execute acceptance
  logic [IDX_W-1:0] exe_idx;
  logic             exe_in_win, exe_done, exe_ok;
  logic [SSN_W-1:0] new_ssn;
  logic [IDX_W-1:0] clr_idx;

  always_comb begin
    exe_idx    = exe_ssn[IDX_W-1:0];
    exe_in_win = (exe_ssn - cmpl_ptr - ONE_SSN) < (disp_ptr - cmpl_ptr);
    exe_done   = slot_vld[exe_idx] && (slot_tag[exe_idx] == exe_ssn);
    exe_ok     = exe_valid && exe_in_win && !exe_done;
    new_ssn    = disp_ptr + ONE_SSN;
    clr_idx    = new_ssn[IDX_W-1:0];
  end

  sq_slots #(
    .SSN_W(SSN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) u_slots (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .clr_en    (disp_fire),
    .clr_idx   (clr_idx),
    .fill_en   (exe_ok),
    .fill_ssn  (exe_ssn),
    .fill_addr (exe_addr),
    .fill_data (exe_data),
    .slot_vld  (slot_vld),
    .slot_tag  (slot_tag),
    .slot_addr (slot_addr),
    .slot_data (slot_data)
  );

  sq_fwd #(
    .SSN_W(SSN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) u_fwd (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .ld_valid     (ld_valid),
    .ld_ssn       (ld_ssn),
    .ld_addr      (ld_addr),
    .disp_ptr     (disp_ptr),
    .cmpl_ptr     (cmpl_ptr),
    .slot_vld     (slot_vld),
    .slot_tag     (slot_tag),
    .slot_addr    (slot_addr),
    .slot_data    (slot_data),
    .ld_rsp_valid (ld_rsp_valid),
    .ld_hit       (ld_hit),
    .ld_data      (ld_data)
  );

  // drain head: oldest not-yet-completed store
  logic [SSN_W-1:0] head_ssn;
  logic [IDX_W-1:0] head_idx;

  always_comb begin
    head_ssn   = cmpl_ptr + ONE_SSN;
    head_idx   = head_ssn[IDX_W-1:0];
    wr_valid   = (cmt_ptr != cmpl_ptr) && slot_vld[head_idx] &&
                 (slot_tag[head_idx] == head_ssn);
    wr_addr    = slot_addr[head_idx];
    wr_data    = slot_data[head_idx];
    drain_fire = wr_valid && wr_ready;
  end
endmodule

// File: rtl/sq_chk.sv
module sq_chk #(
  parameter int SSN_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit_req,
  input logic              ld_valid,
  input logic              ld_rsp_valid,
  input logic              ld_hit,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [SSN_W-1:0]  disp_ptr,
  input logic [SSN_W-1:0]  cmt_ptr,
  input logic [SSN_W-1:0]  cmpl_ptr
);
  localparam logic [SSN_W-1:0] DEPTH_SSN = SSN_W'(DEPTH);
  localparam logic [SSN_W-1:0] ONE_SSN   = SSN_W'(1);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_ptr - cmpl_ptr) <= DEPTH_SSN);

  // R6
  ptr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_ptr - cmpl_ptr) <= (disp_ptr - cmpl_ptr));

  // R6
  cmt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_req |=> $stable(cmt_ptr));

  // R6
  cmt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |=> (cmt_ptr - $past(cmt_ptr)) <= ONE_SSN);

  // R7
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R7
  cmpl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (cmpl_ptr == $past(cmpl_ptr) + ONE_SSN));

  // R7
  cmpl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready) |=> $stable(cmpl_ptr));

  // R5
  ld_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> ld_rsp_valid);

  // R5
  ld_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |-> ld_rsp_valid);
endmodule

bind ssn_store_queue sq_chk #(
  .SSN_W(SSN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
) u_sq_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .commit_req   (commit_req),
  .ld_valid     (ld_valid),
  .ld_rsp_valid (ld_rsp_valid),
  .ld_hit       (ld_hit),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .disp_ptr     (disp_ptr),
  .cmt_ptr      (cmt_ptr),
  .cmpl_ptr     (cmpl_ptr)
);

// File: tb/test_ssn_store_queue.sv
module test_ssn_store_queue;
  localparam int CLK_PERIOD = 10;
  localparam int SSN_W  = 16;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 8;
  localparam int MAXS   = 8191;

  logic clk = 1'b0;
  logic rst_n;
  logic disp_req, exe_valid, ld_valid, commit_req, squash_req, wr_ready;
  logic [SSN_W-1:0]  exe_ssn, ld_ssn, squash_ssn;
  logic [ADDR_W-1:0] exe_addr, ld_addr;
  logic [DATA_W-1:0] exe_data;
  logic disp_ready, ld_rsp_valid, ld_hit, wr_valid;
  logic [DATA_W-1:0] ld_data, wr_data;
  logic [ADDR_W-1:0] wr_addr;
  logic [SSN_W-1:0]  disp_ptr, cmt_ptr, cmpl_ptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssn_store_queue #(.SSN_W(SSN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH))
    i_ssn_store_queue (
      .clk(clk), .rst_n(rst_n), .disp_req(disp_req), .disp_ready(disp_ready),
      .exe_valid(exe_valid), .exe_ssn(exe_ssn), .exe_addr(exe_addr), .exe_data(exe_data),
      .ld_valid(ld_valid), .ld_ssn(ld_ssn), .ld_addr(ld_addr),
      .ld_rsp_valid(ld_rsp_valid), .ld_hit(ld_hit), .ld_data(ld_data),
      .commit_req(commit_req), .squash_req(squash_req), .squash_ssn(squash_ssn),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
      .disp_ptr(disp_ptr), .cmt_ptr(cmt_ptr), .cmpl_ptr(cmpl_ptr));

  int n_chk = 0;
  int n_fail = 0;

  // behavioural reference state
  int m_disp, m_cmt, m_cmpl;
  bit m_ex [0:MAXS];
  logic [ADDR_W-1:0] m_ad [0:MAXS];
  logic [DATA_W-1:0] m_da [0:MAXS];
  bit e_rsp_v, e_hit;
  logic [DATA_W-1:0] e_ld_data;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit m_ready();
    return (m_disp - m_cmpl) != DEPTH;
  endfunction

  function automatic bit m_wrv();
    return (m_cmt != m_cmpl) && m_ex[m_cmpl+1];
  endfunction

  task automatic idle_inputs();
    disp_req = 0; exe_valid = 0; ld_valid = 0; commit_req = 0;
    squash_req = 0; wr_ready = 0;
    exe_ssn = '0; exe_addr = '0; exe_data = '0;
    ld_ssn = '0; ld_addr = '0; squash_ssn = '0;
  endtask

  task automatic compare_all();
    chk("R2,R8 disp_ptr", 64'(disp_ptr), 64'(m_disp));
    chk("R6 cmt_ptr", 64'(cmt_ptr), 64'(m_cmt));
    chk("R7 cmpl_ptr", 64'(cmpl_ptr), 64'(m_cmpl));
    chk("R3 disp_ready", 64'(disp_ready), 64'(m_ready()));
    chk("R7 wr_valid", 64'(wr_valid), 64'(m_wrv()));
    if (m_wrv()) begin
      chk("R7,R4 wr_addr", 64'(wr_addr), 64'(m_ad[m_cmpl+1]));
      chk("R7,R4 wr_data", 64'(wr_data), 64'(m_da[m_cmpl+1]));
    end
    chk("R5 ld_rsp_valid", 64'(ld_rsp_valid), 64'(e_rsp_v));
    chk("R5,R9 ld_hit", 64'(ld_hit), 64'(e_hit));
    if (e_rsp_v) chk("R5,R4 ld_data", 64'(ld_data), 64'(e_ld_data));
  endtask

  // one clock: model next state from pre-edge state and current inputs
  task automatic cyc();
    bit sq_ok, dfire, cadv, exok, wfire, hit;
    int lim, es, ls, ss;
    es = int'(exe_ssn); ls = int'(ld_ssn); ss = int'(squash_ssn);
    sq_ok = squash_req && ss >= m_cmt && ss <= m_disp;
    dfire = disp_req && m_ready() && !sq_ok;
    lim   = sq_ok ? ss : m_disp;
    cadv  = commit_req && (m_cmt != lim);
    exok  = exe_valid && es > m_cmpl && es <= m_disp && !m_ex[es];
    wfire = m_wrv() && wr_ready;
    hit   = ld_valid && ls > m_cmpl && ls <= m_disp && m_ex[ls] && (m_ad[ls] == ld_addr);
    @(posedge clk);
    e_rsp_v = ld_valid;
    e_hit = hit;
    if (ld_valid) e_ld_data = hit ? m_da[ls] : '0;
    if (exok) begin m_ex[es] = 1; m_ad[es] = exe_addr; m_da[es] = exe_data; end
    if (dfire) begin m_disp++; m_ex[m_disp] = 0; end
    if (sq_ok) m_disp = ss;
    if (cadv) m_cmt++;
    if (wfire) m_cmpl++;
    @(negedge clk);
    compare_all();
    idle_inputs();
  endtask

  task automatic do_exe(int s, logic [31:0] a, logic [31:0] d);
    exe_valid = 1; exe_ssn = SSN_W'(s); exe_addr = a; exe_data = d; cyc();
  endtask

  task automatic do_load(int s, logic [31:0] a);
    ld_valid = 1; ld_ssn = SSN_W'(s); ld_addr = a; cyc();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    idle_inputs();
    m_disp = 0; m_cmt = 0; m_cmpl = 0; e_rsp_v = 0; e_hit = 0; e_ld_data = '0;
    for (int i = 0; i <= MAXS; i++) begin m_ex[i] = 0; m_ad[i] = '0; m_da[i] = '0; end
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) cyc();
    // R1 reset state
    chk("R1 disp_ptr", 64'(disp_ptr), 0);
    chk("R1 cmt_ptr", 64'(cmt_ptr), 0);
    chk("R1 cmpl_ptr", 64'(cmpl_ptr), 0);
    chk("R1 disp_ready", 64'(disp_ready), 1);
    chk("R1 wr_valid", 64'(wr_valid), 0);
    chk("R1 ld_rsp_valid", 64'(ld_rsp_valid), 0);

    // R2 dispatch three stores
    for (int i = 0; i < 3; i++) begin disp_req = 1; cyc(); end
    chk("R2 three dispatched", 64'(disp_ptr), 3);

    // R4 execute, duplicate and out-of-window execute ignored
    do_exe(1, 32'h100, 32'hAAAA0001);
    do_exe(2, 32'h200, 32'hAAAA0002);
    do_exe(1, 32'h100, 32'hDEAD0001);
    do_exe(5, 32'h500, 32'hDEAD0005);
    do_load(1, 32'h100);
    chk("R4 duplicate execute ignored", 64'(ld_data), 64'h AAAA0001);
    do_load(5, 32'h500);
    chk("R4 execute beyond dispatch ignored", 64'(ld_hit), 0);

    // R5 forwarding
    do_load(2, 32'h200);
    chk("R5 hit", 64'(ld_hit), 1);
    chk("R5 hit data", 64'(ld_data), 64'h AAAA0002);
    do_load(2, 32'h204);
    chk("R5 address mismatch miss", 64'(ld_hit), 0);
    chk("R5 miss data zero", 64'(ld_data), 0);
    do_load(3, 32'h300);
    chk("R5 unexecuted miss", 64'(ld_hit), 0);

    // R7 nothing drains before commit
    chk("R7 no drain uncommitted", 64'(wr_valid), 0);
    commit_req = 1; cyc();
    chk("R7 drain offered", 64'(wr_valid), 1);
    chk("R7 drain addr", 64'(wr_addr), 64'h100);
    cyc(); cyc();
    chk("R7 held without ready", 64'(wr_data), 64'h AAAA0001);
    chk("R7 cmpl unchanged", 64'(cmpl_ptr), 0);
    for (int i = 0; i < 5; i++) begin commit_req = 1; cyc(); end
    chk("R6 commit capped at dispatch", 64'(cmt_ptr), 3);

    // R10 load and drain of the same store in one cycle
    wr_ready = 1; ld_valid = 1; ld_ssn = 1; ld_addr = 32'h100; cyc();
    chk("R10 load hits draining store", 64'(ld_hit), 1);
    chk("R10 completed", 64'(cmpl_ptr), 1);
    do_load(1, 32'h100);
    chk("R10 completed store misses", 64'(ld_hit), 0);

    wr_ready = 1; cyc();
    chk("R7 waits for execute", 64'(wr_valid), 0);
    do_exe(3, 32'h300, 32'hAAAA0003);
    wr_ready = 1; cyc();
    chk("R7 drained all", 64'(cmpl_ptr), 3);

    // R3 fill to full
    for (int i = 0; i < DEPTH; i++) begin disp_req = 1; cyc(); end
    chk("R3 full stall", 64'(disp_ready), 0);
    disp_req = 1; cyc();
    chk("R3 request ignored when full", 64'(disp_ptr), 11);

    // R8 squash, R9 squashed slots
    do_exe(7, 32'h700, 32'hAAAA0007);
    disp_req = 1; squash_req = 1; squash_ssn = 5; commit_req = 1; cyc();
    chk("R8 squash wins", 64'(disp_ptr), 5);
    squash_req = 1; squash_ssn = 2; cyc();
    chk("R8 squash below commit ignored", 64'(disp_ptr), 5);
    do_load(7, 32'h700);
    chk("R9 squashed miss", 64'(ld_hit), 0);
    disp_req = 1; cyc(); disp_req = 1; cyc();
    do_load(7, 32'h700);
    chk("R9 redispatched unexecuted", 64'(ld_hit), 0);

    // random traffic, compared every cycle
    for (int n = 0; n < 3000; n++) begin
      disp_req   = ($urandom % 3) != 0;
      commit_req = ($urandom % 2) != 0;
      wr_ready   = ($urandom % 4) != 0;
      if (($urandom % 2) != 0) begin
        exe_valid = 1;
        exe_ssn   = SSN_W'(m_cmpl + 1 + int'($urandom % (DEPTH + 1)));
        exe_addr  = 32'($urandom % 4);
        exe_data  = $urandom;
      end
      if (($urandom % 2) != 0) begin
        ld_valid = 1;
        ld_ssn   = SSN_W'(m_cmpl + int'($urandom % (DEPTH + 2)));
        ld_addr  = 32'($urandom % 4);
      end
      if (($urandom % 40) == 0) begin
        squash_req = 1;
        squash_ssn = SSN_W'(m_cmt - 1 + int'($urandom % (m_disp - m_cmt + 3)));
      end
      cyc();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule